// File: doc/BRIEF.md
# Double-Precision Floating Compare Unit

This block takes two 64-bit binary64 values and an operation code and decides one of four relations: equal, less-than, less-or-equal, or unordered. The answer is itself a 64-bit floating word: the value 2.0 (`0x4000000000000000`) stands for true and all zeros for false. A separate invalid flag goes with each answer and reports a signaling NaN among the operands.

Every operand is first sorted into a class: zero, subnormal, normal, infinity, quiet NaN or signaling NaN. When a NaN is present it takes precedence over any magnitude test. Otherwise the ordering comes from the signs and from the sign-less bit patterns. Both signed zeros are treated as one value. Subnormals and infinities are ordered by their magnitudes like any finite value.

Both sides of the block are valid/ready streams with a single output register. An operand pair is taken on a clock edge where `in_valid` and `in_ready` are both high. Its answer is shown on the next cycle and stays there until `out_ready` is high. `in_ready` is high when the output register is empty or is being drained in the same cycle, so the block can take one compare per cycle while the consumer keeps `out_ready` high. When the consumer stalls, the producer has to keep its operands and opcode steady until `in_ready` comes back.

Top module: `fcmp_unit`

## Requirements
- R1: Every result is either `0x4000000000000000` (true) or `0x0000000000000000` (false).
- R2: `in_op` selects the relation as follows: 0 means a equal to b, 1 means a less than b, 2 means a less than or equal to b, 3 means unordered. For op 0 the result is true exactly when the two non-NaN operands are the same value.
- R3: For non-NaN operands, ordering works as follows. A negative operand is below a positive one. With both operands positive, the larger bit pattern in bits 62..0 is the larger value. With both negative, the larger bit pattern is the smaller value. Subnormals and infinities follow the same rule.
- R4: +0 and -0 compare equal in any sign combination. Less-than of two zeros is false, and less-or-equal of two zeros is true.
- R5: An operand is a signaling NaN when bits 62..52 are all ones, bits 51..0 are non-zero and bit 51 is 0. If either operand is one, `out_invalid` is 1. The result is false for ops 0, 1 and 2 and true for op 3.
- R6: An operand is a quiet NaN when bits 62..52 are all ones and bit 51 is 1. If either operand is a quiet NaN and neither is signaling, `out_invalid` is 0. The result is false for ops 0, 1 and 2 and true for op 3.
- R7: When neither operand is a NaN, op 3 returns false and `out_invalid` is 0 for every op.
- R8: After reset `out_valid` is 0 and `in_ready` is 1. A pair accepted on a clock edge shows `out_valid` high after that same edge.
- R9: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_result` and `out_invalid` hold steady. Results leave in the order their pairs were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operand pair and opcode are offered |
| in_ready | output | 1 | The block can accept a pair this cycle |
| in_op | input | 2 | Relation select (0 eq, 1 lt, 2 le, 3 unordered) |
| in_a | input | 64 | Left operand, binary64 |
| in_b | input | 64 | Right operand, binary64 |
| out_valid | output | 1 | A result is held in the output register |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_result | output | 64 | 2.0 when true, zero when false |
| out_invalid | output | 1 | A signaling NaN was among the operands |

## Verification
Random doubles almost never land on NaN codes, signed zeros or neighbouring subnormals. The stimulus therefore places those bit patterns directly, in both operand positions and under all four opcodes. That covers a signaling NaN paired with a quiet one, negative NaNs, a subnormal against the smallest normal, and infinity against the largest finite value. These directed pairs, and a stream of random pairs, are sent while the consumer drops `out_ready` at random. This forces results to wait in the output register and new pairs to wait at the input, so ordering and holding are tested under back-pressure and not only in the idle case.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_SUB  = 3'd1,
    CLS_NORM = 3'd2,
    CLS_INF  = 3'd3,
    CLS_QNAN = 3'd4,
    CLS_SNAN = 3'd5
  } fcls_e;

  typedef enum logic [1:0] {
    OP_EQ = 2'd0,
    OP_LT = 2'd1,
    OP_LE = 2'd2,
    OP_UN = 2'd3
  } fcmp_op_e;

  typedef struct packed {
    logic lt;
    logic eq;
    logic gt;
  } fcmp_rel_t;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] val,
  output fcls_e        cls,
  output logic [W-2:0] mag,
  output logic         neg
);

  localparam int QBIT = FRAC_W - 1;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic exp_ones, exp_zero, frac_zero;

  assign exp_f     = val[W-2 -: EXP_W];
  assign frac_f    = val[FRAC_W-1:0];
  assign exp_ones  = &exp_f;
  assign exp_zero  = ~|exp_f;
  assign frac_zero = ~|frac_f;
  assign mag       = val[W-2:0];
  assign neg       = val[W-1];

  always_comb begin
    if (exp_ones) begin
      if (frac_zero)         cls = CLS_INF;
      else if (frac_f[QBIT]) cls = CLS_QNAN;
      else                   cls = CLS_SNAN;
    end else if (exp_zero) begin
      cls = frac_zero ? CLS_ZERO : CLS_SUB;
    end else begin
      cls = CLS_NORM;
    end
  end

endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
#(
  parameter int MAG_W = 63
) (
  input  logic [MAG_W-1:0] mag_a,
  input  logic [MAG_W-1:0] mag_b,
  input  logic             neg_a,
  input  logic             neg_b,
  input  logic             zero_a,
  input  logic             zero_b,
  output fcmp_rel_t        rel
);

  logic mag_lt, mag_eq, mag_gt;

  assign mag_lt = mag_a < mag_b;
  assign mag_eq = mag_a == mag_b;
  assign mag_gt = mag_a > mag_b;

  always_comb begin
    rel = '0;
    if (zero_a && zero_b) begin
      rel.eq = 1'b1;
    end else if (neg_a != neg_b) begin
      rel.lt = neg_a;
      rel.gt = neg_b;
    end else if (!neg_a) begin
      rel.lt = mag_lt;
      rel.eq = mag_eq;
      rel.gt = mag_gt;
    end else begin
      rel.lt = mag_gt;
      rel.eq = mag_eq;
      rel.gt = mag_lt;
    end
  end

endmodule

// File: rtl/fcmp_resolve.sv
module fcmp_resolve
  import fcmp_pkg::*;
(
  input  logic [1:0] op,
  input  fcls_e      cls_a,
  input  fcls_e      cls_b,
  input  fcmp_rel_t  rel,
  output logic       hit,
  output logic       invalid
);

  logic any_snan, any_nan;

  assign any_snan = (cls_a == CLS_SNAN) || (cls_b == CLS_SNAN);
  assign any_nan  = any_snan || (cls_a == CLS_QNAN) || (cls_b == CLS_QNAN);
  assign invalid  = any_snan;

  always_comb begin
    if (any_nan) begin
      hit = (op == OP_UN);
    end else begin
      unique case (op)
        OP_EQ:   hit = rel.eq;
        OP_LT:   hit = rel.lt;
        OP_LE:   hit = rel.lt | rel.eq;
        default: hit = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [1:0]   in_op,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_result,
  output logic         out_invalid
);

  localparam logic [W-1:0] TRUE_VAL =
    {1'b0, 1'b1, {(EXP_W-1){1'b0}}, {FRAC_W{1'b0}}};

  logic [W-1:0] opnd [2];
  fcls_e        cls  [2];
  logic [W-2:0] mag  [2];
  logic         neg  [2];

  assign opnd[0] = in_a;
  assign opnd[1] = in_b;

  for (genvar gi = 0; gi < 2; gi++) begin : g_cls
    fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .val (opnd[gi]),
      .cls (cls[gi]),
      .mag (mag[gi]),
      .neg (neg[gi])
    );
  end

  fcmp_rel_t rel;

  fcmp_order #(.MAG_W(W-1)) u_order (
    .mag_a  (mag[0]),
    .mag_b  (mag[1]),
    .neg_a  (neg[0]),
    .neg_b  (neg[1]),
    .zero_a (cls[0] == CLS_ZERO),
    .zero_b (cls[1] == CLS_ZERO),
    .rel    (rel)
  );

  logic res_hit, res_invalid;

  fcmp_resolve u_resolve (
    .op      (in_op),
    .cls_a   (cls[0]),
    .cls_b   (cls[1]),
    .rel     (rel),
    .hit     (res_hit),
    .invalid (res_invalid)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_invalid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= res_hit ? TRUE_VAL : '0;
        out_invalid <= res_invalid;
      end
    end
  end

  logic nan_a, nan_b, snan_any;
  assign nan_a    = (cls[0] == CLS_QNAN) || (cls[0] == CLS_SNAN);
  assign nan_b    = (cls[1] == CLS_QNAN) || (cls[1] == CLS_SNAN);
  assign snan_any = (cls[0] == CLS_SNAN) || (cls[1] == CLS_SNAN);

  AST_TRUTH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_result == '0 || out_result == TRUE_VAL)); // R1
  AST_REL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !nan_a && !nan_b) |-> ($countones({rel.lt, rel.eq, rel.gt}) == 1)); // R3
  AST_ZERO_EQ: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cls[0] == CLS_ZERO && cls[1] == CLS_ZERO) |-> rel.eq); // R4
  AST_SNAN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && snan_any) |-> (res_invalid && (res_hit == (in_op == OP_UN)))); // R5
  AST_QNAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !snan_any && (nan_a || nan_b)) |-> (!res_invalid && (res_hit == (in_op == OP_UN)))); // R6
  AST_NONAN_NOINV: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !nan_a && !nan_b) |-> (!res_invalid && !(in_op == OP_UN && res_hit))); // R7
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_invalid))); // R9

endmodule

// File: tb/fcmp_unit_tb.sv
module fcmp_unit_tb;

  localparam logic [63:0] TRUE_W = 64'h4000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = 2'd0;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic        out_invalid;

  always #2.5 clk = ~clk;

  fcmp_unit u_dut (
    .clk, .rst_n, .in_valid, .in_ready, .in_op, .in_a, .in_b,
    .out_valid, .out_ready, .out_result, .out_invalid
  );

  int checks = 0;
  int failures = 0;
  bit stall_en = 1'b0;
  bit done = 1'b0;

  typedef struct {
    logic [63:0] res;
    logic        inv;
    string       tag;
  } exp_t;
  exp_t sb [$];

  function automatic bit is_nan(logic [63:0] x);
    return (x[62:52] == 11'h7ff) && (x[51:0] != 0);
  endfunction

  function automatic logic [63:0] sort_key(logic [63:0] x);
    logic [63:0] y;
    y = (x[62:0] == 0) ? 64'd0 : x;
    return y[63] ? ~y : (y | 64'h8000_0000_0000_0000);
  endfunction

  function automatic exp_t model(logic [63:0] a, logic [63:0] b, logic [1:0] op, string tag);
    exp_t e;
    logic [63:0] ka, kb;
    bit t;
    e.tag = tag;
    if (is_nan(a) || is_nan(b)) begin
      e.inv = (is_nan(a) && !a[51]) || (is_nan(b) && !b[51]);
      t = (op == 2'd3);
    end else begin
      e.inv = 1'b0;
      ka = sort_key(a);
      kb = sort_key(b);
      case (op)
        2'd0: t = (ka == kb);
        2'd1: t = (ka < kb);
        2'd2: t = (ka <= kb);
        default: t = 1'b0;
      endcase
    end
    e.res = t ? TRUE_W : 64'd0;
    return e;
  endfunction

  task automatic check(bit ok, string tag, logic [64:0] act, logic [64:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic send(logic [63:0] a, logic [63:0] b, logic [1:0] op, string tag);
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b; in_op = op;
    while (!in_ready) @(negedge clk);
    sb.push_back(model(a, b, op, tag));
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic all_ops(logic [63:0] a, logic [63:0] b, string tag);
    for (int k = 0; k < 4; k++) send(a, b, k[1:0], tag);
    for (int k = 0; k < 4; k++) send(b, a, k[1:0], tag);
  endtask

  // consumer back-pressure
  always @(posedge clk) begin
    #1 out_ready = stall_en ? (($urandom % 3) != 0) : 1'b1;
  end

  // monitor / scoreboard
  logic        held_v = 1'b0;
  logic [64:0] held_val;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held_v && out_valid)
        check({out_invalid, out_result} == held_val, "R9 stall hold",
              {out_invalid, out_result}, held_val);
      held_v = out_valid && !out_ready;
      held_val = {out_invalid, out_result};
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R9 unexpected result", {out_invalid, out_result}, '0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check({out_invalid, out_result} == {e.inv, e.res}, e.tag,
                {out_invalid, out_result}, {e.inv, e.res});
        end
      end
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL R8 watchdog expired actual=%0d expected=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  localparam logic [63:0] PZ   = 64'h0000_0000_0000_0000;
  localparam logic [63:0] NZ   = 64'h8000_0000_0000_0000;
  localparam logic [63:0] ONE  = 64'h3ff0_0000_0000_0000;
  localparam logic [63:0] TWO  = 64'h4000_0000_0000_0000;
  localparam logic [63:0] NONE = 64'hbff0_0000_0000_0000;
  localparam logic [63:0] NTWO = 64'hc000_0000_0000_0000;
  localparam logic [63:0] SUB1 = 64'h0000_0000_0000_0001;
  localparam logic [63:0] SUB2 = 64'h0000_0000_0000_0002;
  localparam logic [63:0] NSUB = 64'h8000_0000_0000_0001;
  localparam logic [63:0] MINN = 64'h0010_0000_0000_0000;
  localparam logic [63:0] MAXF = 64'h7fef_ffff_ffff_ffff;
  localparam logic [63:0] PINF = 64'h7ff0_0000_0000_0000;
  localparam logic [63:0] NINF = 64'hfff0_0000_0000_0000;
  localparam logic [63:0] QNAN = 64'h7ff8_0000_0000_0000;
  localparam logic [63:0] NQN  = 64'hfff8_0000_0000_0123;
  localparam logic [63:0] SNAN = 64'h7ff0_0000_0000_0001;
  localparam logic [63:0] NSN  = 64'hfff4_0000_0000_0000;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 reset out_valid", {64'd0, out_valid}, 65'd0);
    check(in_ready == 1'b1, "R8 reset in_ready", {64'd0, in_ready}, 65'd1);

    // latency with free consumer
    send(ONE, TWO, 2'd1, "R8 R3 latency 1<2");
    @(negedge clk);
    check(out_valid == 1'b1, "R8 valid one cycle after accept", {64'd0, out_valid}, 65'd1);
    @(negedge clk);

    all_ops(ONE, TWO, "R2 R3 pos normals");
    all_ops(ONE, ONE, "R2 R1 equal values");
    all_ops(NONE, NTWO, "R3 both negative");
    all_ops(NONE, ONE, "R3 mixed signs");
    all_ops(PZ, NZ, "R4 signed zeros");
    all_ops(NZ, NZ, "R4 neg zeros");
    all_ops(SUB1, SUB2, "R3 subnormals");
    all_ops(SUB1, MINN, "R3 subnormal vs min normal");
    all_ops(NSUB, PZ, "R3 R4 neg subnormal vs zero");
    all_ops(PINF, MAXF, "R3 inf vs max");
    all_ops(NINF, NONE, "R3 neg inf");
    all_ops(PINF, PINF, "R2 inf equal");
    all_ops(SNAN, ONE, "R5 snan");
    all_ops(NSN, PINF, "R5 neg snan");
    all_ops(SNAN, QNAN, "R5 snan with qnan");
    all_ops(QNAN, ONE, "R6 qnan");
    all_ops(NQN, NZ, "R6 neg qnan");
    all_ops(QNAN, QNAN, "R6 both qnan");
    all_ops(TWO, NTWO, "R7 unordered false");

    stall_en = 1'b1;
    all_ops(PZ, NZ, "R4 R9 zeros under stall");
    all_ops(SNAN, NQN, "R5 R9 nan under stall");
    for (int i = 0; i < 300; i++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = (i % 5 == 0) ? ra : {$urandom, $urandom};
      if (i % 7 == 0) rb = {~ra[63], ra[62:0]};
      send(ra, rb, i[1:0], "R3 R9 random");
    end
    stall_en = 1'b0;
    repeat (10) @(negedge clk);
    check(sb.size() == 0, "R9 scoreboard drained", {33'd0, sb.size()}, 65'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule